// File: doc/BRIEF.md
# Received Packet Integrity Checker

This block watches a packet stream on a receive user interface: a valid strobe, start and end markers, a channel number, an empty-byte count and a data word of several byte lanes. The packets come from a generator with a fixed pattern. For each packet the checker rebuilds the channel and payload that the generator must have sent. It compares every beat against them and sorts any fault into one of three sticky classes: a bad first beat, a wrong channel, or bad later payload.

It also watches the framing of the stream. A start that arrives while a packet is still open, and any non-start beat that arrives with no packet open, are counted as framing faults. Both error counts stop at their maximum value. Received start and end markers are counted. A flag rises when those counts come to equal the transmit-side counts that enter on input ports. A pass output combines the result: no sticky flags, no framing faults, and equal counts.

A small register port reads the counters and flags. The same port clears the error state or clears the count-equal flag.

Top module: `pkt_rx_checker`

## Requirements
- R1: The expected packet number n is 0 after reset and advances by one on every valid beat that carries the end marker, including an end marker that arrives with no open packet.
- R2: Byte index k of packet n is expected to be (n + k) mod 256. Within beat b, byte lane j sits at data bits [8j+7:8j] and carries k = b*BYTES + j. A mismatch on a start beat sets flag bit 0, and a mismatch on any later beat sets flag bit 2.
- R3: On a start beat the channel must equal n mod NCHAN, and a wrong channel sets flag bit 1. The channel on a beat without a start marker is ignored.
- R4: Flag bits stay set until bit 0 of a write to address 6 is 1. That write clears the flags, the framing count and the mismatch count.
- R5: On a beat that carries the end marker, the `empty` value gives the number of highest-numbered lanes that are not compared.
- R6: Each of the following adds one to the framing count (address 3): a start marker while a packet is open (a missing end), or a valid beat with no start marker while no packet is open (a missing start). The data of a missing-start beat is not compared.
- R7: The received start count and end count are readable at addresses 0 and 1. Each adds one per valid beat that carries the matching marker.
- R8: `match_flag` is set one cycle after both received counts become equal to the transmit counts, if they were not equal in the cycle before. Writing 1 in bit 0 to address 7 clears it. It also reads at address 5, bit 0.
- R9: The framing count and the mismatch count saturate at all ones instead of wrapping.
- R10: `test_pass` is high exactly when all flags are clear, the framing count is zero and both received counts currently equal the transmit counts.
- R11: The mismatch count (address 4) adds one for each valid beat that raises at least one of the three data or channel faults. Flag bits appear on `err_flags` and at address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Beat valid |
| rx_sop | input | 1 | Start marker of a packet |
| rx_eop | input | 1 | End marker of a packet |
| rx_chan | input | CHAN_W | Channel number, checked on start beats |
| rx_empty | input | EMPTY_W | Unused high lanes on an end beat |
| rx_data | input | 8*BYTES | Data word, lane j at bits [8j+7:8j] |
| tx_sop_cnt | input | CNT_W | Transmit-side start count |
| tx_eop_cnt | input | CNT_W | Transmit-side end count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wcmd | input | 1 | Bit 0 of the write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| err_flags | output | 3 | Sticky flags: bit0 first beat, bit1 channel, bit2 payload |
| match_flag | output | 1 | Count-equal flag |
| test_pass | output | 1 | Overall pass indication |

## Verification
The hardest state to reach is a framing fault that hides inside a stream that still looks correct. One such case is a second start marker while a packet is open: it reuses the same expected packet number, so its data must still match. Another is a stray end marker with no open packet: it must still move the packet number forward, so the next packet is checked against n+1. The stimulus builds these cases from directed beats. It then sends a clean packet and checks that no flag appears. The count-equal flag is reached by loading transmit counts one ahead of the received counts and closing the gap with a single packet.

// File: rtl/pkt_chk_pkg.sv
package pkt_chk_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_RX_SOP    = 3'd0,
    RA_RX_EOP    = 3'd1,
    RA_FLAGS     = 3'd2,
    RA_FRAME     = 3'd3,
    RA_MISM      = 3'd4,
    RA_MATCH     = 3'd5,
    RA_CLR_ERR   = 3'd6,
    RA_CLR_MATCH = 3'd7
  } reg_addr_e;

  // expected byte at byte index idx of packet seq
  function automatic logic [7:0] pat_byte(input logic [31:0] seq, input logic [31:0] idx);
    return 8'(seq + idx);
  endfunction

  // expected channel of packet seq
  function automatic logic [31:0] pat_chan(input logic [31:0] seq, input int unsigned nchan);
    return seq % 32'(nchan);
  endfunction

endpackage

// File: rtl/pkt_chk_satcnt.sv
module pkt_chk_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 q <= '0;
    else if (clr)               q <= '0;
    else if (inc && q != TOP)   q <= q + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q == TOP && !clr) |=> (q == TOP));  // R9

endmodule

// File: rtl/pkt_chk_framer.sv
module pkt_chk_framer #(
  parameter int SEQ_W  = 16,
  parameter int BEAT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              sop,
  input  logic              eop,
  output logic              open_q,
  output logic [SEQ_W-1:0]  seq_q,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              miss_sop,
  output logic              miss_eop
);
  logic [BEAT_W-1:0] beat_q;

  assign beat_idx = sop ? '0 : beat_q;
  assign miss_eop = valid && sop && open_q;
  assign miss_sop = valid && !sop && !open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      beat_q <= '0;
      seq_q  <= '0;
    end else if (valid) begin
      if (sop) begin
        open_q <= !eop;
        beat_q <= BEAT_W'(1);
      end else if (open_q) begin
        beat_q <= beat_q + 1'b1;
        if (eop) open_q <= 1'b0;
      end
      if (eop) seq_q <= seq_q + 1'b1;
    end
  end

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && eop) |=> $stable(seq_q));  // R1
  AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && eop) |=> !open_q);  // R6

endmodule

// File: rtl/pkt_chk_expect.sv
module pkt_chk_expect
  import pkt_chk_pkg::*;
#(
  parameter int BYTES   = 4,
  parameter int NCHAN   = 4,
  parameter int SEQ_W   = 16,
  parameter int BEAT_W  = 12,
  parameter int CHAN_W  = 2,
  parameter int EMPTY_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEQ_W-1:0]   seq,
  input  logic [BEAT_W-1:0]  beat,
  input  logic [8*BYTES-1:0] data,
  input  logic [EMPTY_W-1:0] empty,
  input  logic               last,
  input  logic [CHAN_W-1:0]  chan,
  output logic [BYTES-1:0]   lane_bad,
  output logic               chan_bad
);
  logic [BYTES-1:0] lane_live;

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic [7:0] exp_b;
    assign exp_b        = pat_byte(32'(seq), 32'(beat) * 32'(BYTES) + 32'(j));
    assign lane_live[j] = !last || (32'(j) < 32'(BYTES) - 32'(empty));
    assign lane_bad[j]  = lane_live[j] && (data[8*j +: 8] != exp_b);
  end

  assign chan_bad = (32'(chan) != pat_chan(32'(seq), NCHAN));

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (last && 32'(empty) == 32'(BYTES - 1)) |-> (lane_bad[BYTES-1:1] == '0));  // R5

endmodule

// File: rtl/pkt_rx_checker.sv
module pkt_rx_checker
  import pkt_chk_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int NCHAN  = 4,
  parameter int CNT_W  = 16,
  parameter int ERR_W  = 8,
  parameter int SEQ_W  = 16,
  parameter int BEAT_W = 12,
  localparam int DATA_W  = 8 * BYTES,
  localparam int CHAN_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int EMPTY_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic               rx_sop,
  input  logic               rx_eop,
  input  logic [CHAN_W-1:0]  rx_chan,
  input  logic [EMPTY_W-1:0] rx_empty,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic [CNT_W-1:0]   tx_sop_cnt,
  input  logic [CNT_W-1:0]   tx_eop_cnt,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic               reg_wcmd,
  output logic [31:0]        reg_rdata,
  output logic [2:0]         err_flags,
  output logic               match_flag,
  output logic               test_pass
);
  // ---- framing ----
  logic              open_q, miss_sop, miss_eop;
  logic [SEQ_W-1:0]  seq_q;
  logic [BEAT_W-1:0] beat_idx;

  pkt_chk_framer #(.SEQ_W(SEQ_W), .BEAT_W(BEAT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .sop(rx_sop), .eop(rx_eop),
    .open_q(open_q), .seq_q(seq_q), .beat_idx(beat_idx),
    .miss_sop(miss_sop), .miss_eop(miss_eop)
  );

  // ---- expected value regeneration ----
  logic [BYTES-1:0] lane_bad;
  logic             chan_bad;

  pkt_chk_expect #(
    .BYTES(BYTES), .NCHAN(NCHAN), .SEQ_W(SEQ_W), .BEAT_W(BEAT_W),
    .CHAN_W(CHAN_W), .EMPTY_W(EMPTY_W)
  ) u_expect (
    .clk(clk), .rst_n(rst_n), .seq(seq_q), .beat(beat_idx), .data(rx_data),
    .empty(rx_empty), .last(rx_eop), .chan(rx_chan),
    .lane_bad(lane_bad), .chan_bad(chan_bad)
  );

  // ---- classification ----
  logic any_lane_bad, hit_first, hit_chan, hit_pay, hit_any;
  logic clr_err, clr_match;

  assign any_lane_bad = |lane_bad;
  assign hit_first    = rx_valid && rx_sop && any_lane_bad;
  assign hit_chan     = rx_valid && rx_sop && chan_bad;
  assign hit_pay      = rx_valid && !rx_sop && open_q && any_lane_bad;
  assign hit_any      = hit_first || hit_chan || hit_pay;
  assign clr_err      = reg_wr && (reg_addr == RA_CLR_ERR)   && reg_wcmd;
  assign clr_match    = reg_wr && (reg_addr == RA_CLR_MATCH) && reg_wcmd;

  always_ff @(posedge clk) begin
    if (!rst_n)       err_flags <= '0;
    else if (clr_err) err_flags <= '0;
    else              err_flags <= err_flags | {hit_pay, hit_chan, hit_first};
  end

  // ---- error counts ----
  logic [ERR_W-1:0] frame_cnt, mism_cnt;

  pkt_chk_satcnt #(.W(ERR_W)) u_frame_cnt (
    .clk(clk), .rst_n(rst_n), .inc(miss_sop || miss_eop), .clr(clr_err), .q(frame_cnt)
  );
  pkt_chk_satcnt #(.W(ERR_W)) u_mism_cnt (
    .clk(clk), .rst_n(rst_n), .inc(hit_any), .clr(clr_err), .q(mism_cnt)
  );

  // ---- marker counts and comparison ----
  logic [CNT_W-1:0] rx_sop_cnt, rx_eop_cnt;
  logic             cnt_eq, eq_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sop_cnt <= '0;
      rx_eop_cnt <= '0;
    end else if (rx_valid) begin
      if (rx_sop) rx_sop_cnt <= rx_sop_cnt + 1'b1;
      if (rx_eop) rx_eop_cnt <= rx_eop_cnt + 1'b1;
    end
  end

  assign cnt_eq = (rx_sop_cnt == tx_sop_cnt) && (rx_eop_cnt == tx_eop_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_prev    <= 1'b1;
      match_flag <= 1'b0;
    end else begin
      eq_prev <= cnt_eq;
      if (clr_match)               match_flag <= 1'b0;
      else if (cnt_eq && !eq_prev) match_flag <= 1'b1;
    end
  end

  assign test_pass = (err_flags == '0) && (frame_cnt == '0) && cnt_eq;

  // ---- register read ----
  always_comb begin
    case (reg_addr)
      RA_RX_SOP: reg_rdata = 32'(rx_sop_cnt);
      RA_RX_EOP: reg_rdata = 32'(rx_eop_cnt);
      RA_FLAGS:  reg_rdata = 32'(err_flags);
      RA_FRAME:  reg_rdata = 32'(frame_cnt);
      RA_MISM:   reg_rdata = 32'(mism_cnt);
      RA_MATCH:  reg_rdata = 32'(match_flag);
      default:   reg_rdata = '0;
    endcase
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_err |=> ((err_flags & $past(err_flags)) == $past(err_flags)));  // R4
  AST_CHAN_SOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rx_valid && rx_sop) && !clr_err) |=> (err_flags[1] == $past(err_flags[1])));  // R3
  AST_EOPCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eop) |=> $stable(rx_eop_cnt));  // R7
  AST_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_match |=> !match_flag);  // R8

endmodule

// File: tb/pkt_rx_checker_bench.sv
module pkt_rx_checker_bench;
  localparam int BYTES = 4;
  localparam int NCHAN = 4;
  localparam int CNT_W = 16;
  localparam int ERR_W = 8;
  localparam int CHAN_W = 2;
  localparam int EMPTY_W = 2;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sop = 0, rx_eop = 0;
  logic [CHAN_W-1:0] rx_chan = '0;
  logic [EMPTY_W-1:0] rx_empty = '0;
  logic [8*BYTES-1:0] rx_data = '0;
  logic [CNT_W-1:0] tx_sop_cnt = 16'd100, tx_eop_cnt = 16'd100;
  logic reg_wr = 0, reg_wcmd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_rdata;
  logic [2:0] err_flags;
  logic match_flag, test_pass;

  always #2.5 clk = ~clk;

  pkt_rx_checker u_pkt_rx_checker (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_chan(rx_chan), .rx_empty(rx_empty), .rx_data(rx_data),
    .tx_sop_cnt(tx_sop_cnt), .tx_eop_cnt(tx_eop_cnt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wcmd(reg_wcmd), .reg_rdata(reg_rdata),
    .err_flags(err_flags), .match_flag(match_flag), .test_pass(test_pass)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  // bench model state
  int n_m = 0, beat_m = 0, sop_m = 0, eop_m = 0, mism_m = 0, frame_m = 0;
  bit open_m = 0;
  logic [2:0] flags_m = '0;

  // stimulus table: [0] sop [1] eop [3:2] empty [7:4] corrupted lanes [8] wrong channel
  localparam logic [8:0] TBL [8] = '{
    9'b0_0000_00_01,   // start of packet 0
    9'b0_0000_00_00,   // middle beat
    9'b0_0000_01_10,   // end, one empty lane
    9'b0_1000_11_11,   // single beat, three empty lanes, corrupt lane 3 masked (R5)
    9'b1_0000_00_01,   // start with wrong channel (R3)
    9'b0_0010_00_10,   // end with payload fault on lane 1 (R2)
    9'b0_0001_00_01,   // start with first-beat fault on lane 0 (R2)
    9'b0_0000_00_10    // clean end
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a);
    reg_wr = 1; reg_addr = a; reg_wcmd = 1;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; reg_wcmd = 0;
    flags_m = (a == 3'd6) ? 3'b000 : flags_m;
    if (a == 3'd6) begin mism_m = 0; frame_m = 0; end
  endtask

  task automatic send(input bit s, input bit e, input int emp,
                      input logic [BYTES-1:0] cmask, input bit badch);
    int off;
    bit bad;
    off = s ? 0 : beat_m;
    bad = 0;
    for (int j = 0; j < BYTES; j++) begin
      rx_data[8*j +: 8] = 8'(n_m + off*BYTES + j) ^ (cmask[j] ? 8'hFF : 8'h00);
      if (cmask[j] && (!e || j < BYTES - emp)) bad = 1;
    end
    rx_chan  = CHAN_W'((n_m + (badch ? 1 : 0)) % NCHAN);
    rx_empty = EMPTY_W'(emp);
    rx_sop = s; rx_eop = e; rx_valid = 1;
    @(posedge clk); @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
    if (s) begin
      if (open_m && frame_m < ERR_MAX) frame_m++;
      if (bad) flags_m[0] = 1;
      if (badch) flags_m[1] = 1;
      if ((bad || badch) && mism_m < ERR_MAX) mism_m++;
      open_m = !e; beat_m = 1; sop_m++;
    end else if (open_m) begin
      if (bad) begin flags_m[2] = 1; if (mism_m < ERR_MAX) mism_m++; end
      beat_m++;
      if (e) open_m = 0;
    end else if (frame_m < ERR_MAX) frame_m++;
    if (e) begin n_m++; eop_m++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk("R4 reset flags", 32'(err_flags), 0);
    rd(3'd0, d); chk("R7 reset sop count", d, 0);
    rd(3'd1, d); chk("R7 reset eop count", d, 0);
    rd(3'd4, d); chk("R11 reset mismatch count", d, 0);
    rd(3'd5, d); chk("R8 reset match", d, 0);

    // table walk: R2, R3, R5, R11
    for (int i = 0; i < 8; i++) begin
      send(TBL[i][0], TBL[i][1], int'(TBL[i][3:2]), TBL[i][7:4], TBL[i][8]);
      chk("R2/R3 table flags", 32'(err_flags), 32'(flags_m));
      rd(3'd4, d); chk("R11 table mismatch count", d, 32'(mism_m));
      if (i == 3) chk("R5 masked lane", 32'(err_flags), 0);
    end
    rd(3'd2, d); chk("R11 flags register", d, 32'(flags_m));

    // clear errors
    wr(3'd6);
    chk("R4 cleared flags", 32'(err_flags), 0);
    rd(3'd4, d); chk("R4 cleared mismatch count", d, 0);

    // framing faults: R6
    send(0, 0, 0, 4'b1111, 0);  // missing start, garbage data not compared
    rd(3'd3, d); chk("R6 missing start", d, 1);
    chk("R6 no data compare", 32'(err_flags), 0);
    send(1, 0, 0, 4'b0000, 0);
    send(1, 0, 0, 4'b0000, 0);  // missing end, same packet number
    rd(3'd3, d); chk("R6 missing end", d, 2);
    send(0, 1, 0, 4'b0000, 0);
    send(0, 1, 0, 4'b0000, 0);  // stray end: missing start, number still advances
    rd(3'd3, d); chk("R6 stray end", d, 3);
    chk("R6 flags clean", 32'(err_flags), 0);
    rd(3'd0, d); chk("R7 sop count", d, 32'(sop_m));
    rd(3'd1, d); chk("R7 eop count", d, 32'(eop_m));

    // count comparison: R8, R10, R1
    wr(3'd6);
    tx_sop_cnt = CNT_W'(sop_m + 1);
    tx_eop_cnt = CNT_W'(eop_m + 1);
    send(1, 1, 0, 4'b0000, 0);
    chk("R1 advance after stray end", 32'(err_flags), 0);
    chk("R8 not yet set", 32'(match_flag), 0);
    @(posedge clk); @(negedge clk);
    chk("R8 match set", 32'(match_flag), 1);
    rd(3'd5, d); chk("R8 match register", d, 1);
    chk("R10 pass", 32'(test_pass), 1);
    wr(3'd7);
    chk("R8 match cleared", 32'(match_flag), 0);
    send(1, 1, 0, 4'b0000, 1);
    chk("R10 no pass after fault", 32'(test_pass), 0);

    // saturation: R9
    wr(3'd6);
    for (int i = 0; i < 300; i++) send(1, 1, 0, 4'b0000, 1);
    rd(3'd4, d); chk("R9 mismatch saturates", d, 32'(ERR_MAX));
    chk("R9 model agrees", 32'(mism_m), 32'(ERR_MAX));
    chk("R3 channel flag", 32'(err_flags), 3'b010);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule